// File: doc/BRIEF.md
# Multicast Admission and Release Tracker

This block admits multicast frames into per-port, per-class transmit FIFOs and decides when each frame's buffer can be freed. Each forwarding result carries a buffer handle, a traffic class and a mask of destination ports. The block first applies a global admission test. That test compares the buffers in use plus the buffers held in reserve against a limit. When it fails, the frame is dropped at every destination and its handle is returned at once. Otherwise each destination is judged on its own. A destination is dropped if its FIFO for that class is deeper than a depth limit, or if that FIFO is full.

Every surviving destination gets the handle pushed into its physical FIFO for that class. A per-handle reference count is loaded with the number of survivors. Transmit ports report when they have read the end of a frame. Each report lowers the count, and the report that brings it to zero returns the handle. If no destination survives, the handle is returned straight away, the same as for a global drop.

Top module: `mcast_admit_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no admission, drop release, dequeue or end-of-frame release output is valid. All FIFOs start empty and all reference counts start at zero.
- R2: If buf_used + buf_resv > glob_limit, the frame is dropped everywhere. The next cycle shows adm_valid=1, adm_kept=0, drop_rel_valid=1 and drop_rel_handle equal to the handle, and no FIFO is written.
- R3: Otherwise, destination port p (bit p of fwd_mask) survives only if its FIFO for the frame's class holds no more than qdepth_limit entries. adm_kept, one cycle later, holds exactly the survivors.
- R4: A FIFO that already holds DEPTH entries counts as a selective drop for that destination, whatever qdepth_limit is.
- R5: If no destination survives, including the case of an empty mask, the handle is returned on drop_rel_valid/drop_rel_handle one cycle later.
- R6: Each survivor's FIFO (port p, class c) receives the handle. A dequeue request for port p with class field c (bits p*2 +: 2 of deq_class) returns the oldest entry one cycle later on deq_valid[p] and deq_handle bits p*6 +: 6. Entries come out in FIFO order. Occupancy is judged before any dequeue in the same cycle.
- R7: A dequeue request to an empty FIFO yields deq_valid[p]=0.
- R8: A handle's count is loaded with the number of survivors. eof_valid[p] with handle bits p*6 +: 6 lowers it. One cycle after the report that brings it to zero, eof_rel_valid[p] is 1 and eof_rel_handle bits p*6 +: 6 carry the handle. Earlier reports release nothing.
- R9: When several ports report the same handle in one cycle, the count drops by the number of reports, saturating at zero. A resulting release appears only on the lowest-numbered reporting port.
- R10: An end-of-frame report for a handle whose count is zero is ignored, and no release follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_valid | input | 1 | Forwarding result present |
| fwd_handle | input | 6 | Buffer handle of the frame |
| fwd_class | input | 2 | Traffic class |
| fwd_mask | input | 4 | Destination port mask |
| buf_used | input | 12 | Buffers in use |
| buf_resv | input | 12 | Buffers reserved |
| glob_limit | input | 12 | Global drop limit |
| qdepth_limit | input | 4 | Per-FIFO depth limit for selective drop |
| deq_req | input | 4 | Per-port dequeue request |
| deq_class | input | 8 | Per-port class to dequeue, 2 bits each |
| deq_valid | output | 4 | Dequeued entry present, per port |
| deq_handle | output | 24 | Dequeued handle, 6 bits per port |
| eof_valid | input | 4 | Per-port end-of-frame-read report |
| eof_handle | input | 24 | Handle of the report, 6 bits per port |
| adm_valid | output | 1 | Admission result present |
| adm_kept | output | 4 | Surviving destinations |
| drop_rel_valid | output | 1 | Handle returned by a drop |
| drop_rel_handle | output | 6 | Handle returned by a drop |
| eof_rel_valid | output | 4 | Handle returned after last read, per port |
| eof_rel_handle | output | 24 | Returned handle, 6 bits per port |

## Verification
Every result of this block is registered once. The admission mask and drop release, the dequeued handle, and the end-of-frame release all appear on the clock edge after the inputs that cause them. The bench drives each stimulus on a falling edge. It advances a behavioural model of the FIFOs and counts in the same step, and compares every output on the next falling edge. That comparison falls exactly one rising edge after the stimulus. Handles are compared only where their valid bit is expected high.

// File: rtl/mat_pkg.sv
package mat_pkg;
  function automatic int unsigned count_set(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/mat_decide.sv
module mat_decide #(
  parameter int NPORT  = 4,
  parameter int NCLASS = 4,
  parameter int DEPTH  = 8,
  parameter int BUFW   = 12,
  parameter int CLW    = 2,
  parameter int QCW    = 4
) (
  input  logic                      fwd_valid,
  input  logic [CLW-1:0]            fwd_class,
  input  logic [NPORT-1:0]          fwd_mask,
  input  logic [BUFW-1:0]           buf_used,
  input  logic [BUFW-1:0]           buf_resv,
  input  logic [BUFW-1:0]           glob_limit,
  input  logic [QCW-1:0]            qdepth_limit,
  input  logic [NPORT*NCLASS*QCW-1:0] q_levels,
  output logic [NPORT-1:0]          kept
);
  logic           glob_drop;
  logic [BUFW:0]  demand;
  logic [QCW-1:0] lvl;

  always_comb begin
    demand    = {1'b0, buf_used} + {1'b0, buf_resv};
    glob_drop = demand > {1'b0, glob_limit};
    kept      = '0;
    lvl       = '0;
    for (int p = 0; p < NPORT; p++) begin
      lvl = q_levels[(p*NCLASS + int'(fwd_class))*QCW +: QCW];
      kept[p] = fwd_valid && fwd_mask[p] && !glob_drop &&
                !(lvl > qdepth_limit) && (lvl != QCW'(DEPTH));
    end
  end
endmodule

// File: rtl/mat_mcq.sv
module mat_mcq #(
  parameter int HW    = 6,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_data,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [HW-1:0] rd_data,
  output logic [CW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [HW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign do_rd = rd_en && (level != '0);
  assign do_wr = wr_en && (level != CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/mat_refcnt.sv
module mat_refcnt #(
  parameter int NPORT = 4,
  parameter int HW    = 6,
  parameter int RCW   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [HW-1:0]       load_handle,
  input  logic [RCW-1:0]      load_val,
  input  logic [NPORT-1:0]    eof_valid,
  input  logic [NPORT*HW-1:0] eof_handle,
  output logic [NPORT-1:0]    rel_valid,
  output logic [NPORT*HW-1:0] rel_handle
);
  localparam int NH = 1 << HW;

  logic [RCW-1:0] cnt      [NH];
  logic [RCW-1:0] hits     [NH];
  logic [RCW-1:0] port_n   [NPORT];
  logic [NPORT-1:0] lower_dup;

  always_comb begin
    for (int h = 0; h < NH; h++) begin
      hits[h] = '0;
      for (int p = 0; p < NPORT; p++)
        if (eof_valid[p] && eof_handle[p*HW +: HW] == HW'(h))
          hits[h] = hits[h] + RCW'(1);
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      port_n[p]    = hits[eof_handle[p*HW +: HW]];
      lower_dup[p] = 1'b0;
      for (int r = 0; r < p; r++)
        if (eof_valid[r] && eof_handle[r*HW +: HW] == eof_handle[p*HW +: HW])
          lower_dup[p] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int h = 0; h < NH; h++) cnt[h] <= '0;
    end else begin
      for (int h = 0; h < NH; h++) begin
        if (load_en && load_handle == HW'(h))
          cnt[h] <= load_val;
        else if (cnt[h] != '0 && hits[h] != '0)
          cnt[h] <= (cnt[h] > hits[h]) ? cnt[h] - hits[h] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid  <= '0;
      rel_handle <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        rel_valid[p] <= eof_valid[p] && !lower_dup[p] &&
                        (cnt[eof_handle[p*HW +: HW]] != '0) &&
                        (cnt[eof_handle[p*HW +: HW]] <= port_n[p]);
        rel_handle[p*HW +: HW] <= eof_handle[p*HW +: HW];
      end
    end
  end
endmodule

// File: rtl/mcast_admit_tracker.sv
module mcast_admit_tracker #(
  parameter int NPORT  = 4,
  parameter int NCLASS = 4,
  parameter int HW     = 6,
  parameter int DEPTH  = 8,
  parameter int BUFW   = 12,
  localparam int CLW   = (NCLASS > 1) ? $clog2(NCLASS) : 1,
  localparam int QCW   = $clog2(DEPTH+1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fwd_valid,
  input  logic [HW-1:0]         fwd_handle,
  input  logic [CLW-1:0]        fwd_class,
  input  logic [NPORT-1:0]      fwd_mask,
  input  logic [BUFW-1:0]       buf_used,
  input  logic [BUFW-1:0]       buf_resv,
  input  logic [BUFW-1:0]       glob_limit,
  input  logic [QCW-1:0]        qdepth_limit,
  input  logic [NPORT-1:0]      deq_req,
  input  logic [NPORT*CLW-1:0]  deq_class,
  output logic [NPORT-1:0]      deq_valid,
  output logic [NPORT*HW-1:0]   deq_handle,
  input  logic [NPORT-1:0]      eof_valid,
  input  logic [NPORT*HW-1:0]   eof_handle,
  output logic                  adm_valid,
  output logic [NPORT-1:0]      adm_kept,
  output logic                  drop_rel_valid,
  output logic [HW-1:0]         drop_rel_handle,
  output logic [NPORT-1:0]      eof_rel_valid,
  output logic [NPORT*HW-1:0]   eof_rel_handle
);
  import mat_pkg::*;

  localparam int NQ  = NPORT * NCLASS;
  localparam int RCW = $clog2(NPORT+1);

  logic [NQ*QCW-1:0] q_levels;
  logic [NQ-1:0]     q_rv;
  logic [NQ*HW-1:0]  q_rd;
  logic [NPORT-1:0]  kept;
  logic              load_en;
  logic [RCW-1:0]    load_val;

  mat_decide #(
    .NPORT(NPORT), .NCLASS(NCLASS), .DEPTH(DEPTH),
    .BUFW(BUFW), .CLW(CLW), .QCW(QCW)
  ) u_decide (
    .fwd_valid(fwd_valid), .fwd_class(fwd_class), .fwd_mask(fwd_mask),
    .buf_used(buf_used), .buf_resv(buf_resv), .glob_limit(glob_limit),
    .qdepth_limit(qdepth_limit), .q_levels(q_levels), .kept(kept)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar c = 0; c < NCLASS; c++) begin : g_cls
      localparam int IDX = p*NCLASS + c;
      mat_mcq #(.HW(HW), .DEPTH(DEPTH), .CW(QCW)) u_q (
        .clk(clk), .rst(rst),
        .wr_en(kept[p] && fwd_class == CLW'(c)),
        .wr_data(fwd_handle),
        .rd_en(deq_req[p] && deq_class[p*CLW +: CLW] == CLW'(c)),
        .rd_valid(q_rv[IDX]),
        .rd_data(q_rd[IDX*HW +: HW]),
        .level(q_levels[IDX*QCW +: QCW])
      );
    end
  end

  always_comb begin
    deq_valid  = '0;
    deq_handle = '0;
    for (int p = 0; p < NPORT; p++)
      for (int c = 0; c < NCLASS; c++)
        if (q_rv[p*NCLASS + c]) begin
          deq_valid[p]            = 1'b1;
          deq_handle[p*HW +: HW]  = deq_handle[p*HW +: HW] | q_rd[(p*NCLASS + c)*HW +: HW];
        end
  end

  assign load_en  = fwd_valid && (kept != '0);
  assign load_val = RCW'(count_set(32'(kept)));

  mat_refcnt #(.NPORT(NPORT), .HW(HW), .RCW(RCW)) u_refcnt (
    .clk(clk), .rst(rst),
    .load_en(load_en), .load_handle(fwd_handle), .load_val(load_val),
    .eof_valid(eof_valid), .eof_handle(eof_handle),
    .rel_valid(eof_rel_valid), .rel_handle(eof_rel_handle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      adm_valid       <= 1'b0;
      adm_kept        <= '0;
      drop_rel_valid  <= 1'b0;
      drop_rel_handle <= '0;
    end else begin
      adm_valid       <= fwd_valid;
      adm_kept        <= kept;
      drop_rel_valid  <= fwd_valid && (kept == '0);
      drop_rel_handle <= fwd_handle;
    end
  end
endmodule

// File: rtl/mat_chk.sv
module mat_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] fwd_mask,
  input logic [NPORT-1:0] deq_req,
  input logic [NPORT-1:0] deq_valid,
  input logic [NPORT-1:0] eof_valid,
  input logic [NPORT-1:0] eof_rel_valid,
  input logic             adm_valid,
  input logic [NPORT-1:0] adm_kept,
  input logic             drop_rel_valid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!adm_valid && !drop_rel_valid && deq_valid == '0 && eof_rel_valid == '0));

  // R2
  drop_means_none_kept_chk: assert property (@(posedge clk) disable iff (rst)
    drop_rel_valid |-> (adm_valid && adm_kept == '0));

  // R3
  kept_within_mask_chk: assert property (@(posedge clk) disable iff (rst)
    adm_valid |-> ((adm_kept & ~$past(fwd_mask)) == '0));

  // R5
  none_kept_releases_chk: assert property (@(posedge clk) disable iff (rst)
    (adm_valid && adm_kept == '0) |-> drop_rel_valid);

  // R6
  deq_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    (deq_valid & ~$past(deq_req)) == '0);

  // R8
  release_needs_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (eof_rel_valid & ~$past(eof_valid)) == '0);
endmodule

bind mcast_admit_tracker mat_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .fwd_mask(fwd_mask), .deq_req(deq_req),
  .deq_valid(deq_valid), .eof_valid(eof_valid), .eof_rel_valid(eof_rel_valid),
  .adm_valid(adm_valid), .adm_kept(adm_kept), .drop_rel_valid(drop_rel_valid)
);

// File: tb/mcast_admit_tracker_tb.sv
module mcast_admit_tracker_tb;
  localparam int NPORT = 4, NCLASS = 4, HW = 6, DEPTH = 8, BUFW = 12;
  localparam int CLW = 2, QCW = 4, NH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                 fwd_valid = 0;
  logic [HW-1:0]        fwd_handle = 0;
  logic [CLW-1:0]       fwd_class = 0;
  logic [NPORT-1:0]     fwd_mask = 0;
  logic [BUFW-1:0]      buf_used = 10, buf_resv = 10, glob_limit = 100;
  logic [QCW-1:0]       qdepth_limit = 15;
  logic [NPORT-1:0]     deq_req = 0;
  logic [NPORT*CLW-1:0] deq_class = 0;
  logic [NPORT-1:0]     eof_valid = 0;
  logic [NPORT*HW-1:0]  eof_handle = 0;
  logic [NPORT-1:0]     deq_valid, adm_kept, eof_rel_valid;
  logic [NPORT*HW-1:0]  deq_handle, eof_rel_handle;
  logic                 adm_valid, drop_rel_valid;
  logic [HW-1:0]        drop_rel_handle;

  mcast_admit_tracker u_dut (.*);

  int q [NPORT][NCLASS][$];
  int cnt [NH];
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  logic e_adm_v = 0, e_drop_v = 0;
  logic [NPORT-1:0] e_kept = 0, e_deq_v = 0, e_rel_v = 0;
  int e_drop_h = 0;
  int e_deq_h [NPORT];
  int e_rel_h [NPORT];

  task automatic chk(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 adm_valid", longint'(adm_valid), longint'(e_adm_v));
    chk("R3 adm_kept", longint'(adm_kept), longint'(e_kept));
    chk("R5 drop_rel_valid", longint'(drop_rel_valid), longint'(e_drop_v));
    if (e_drop_v) chk("R5 drop_rel_handle", longint'(drop_rel_handle), longint'(e_drop_h));
    for (int p = 0; p < NPORT; p++) begin
      chk($sformatf("R6 deq_valid[%0d]", p), longint'(deq_valid[p]), longint'(e_deq_v[p]));
      if (e_deq_v[p]) chk($sformatf("R6 deq_handle[%0d]", p), longint'(deq_handle[p*HW +: HW]), longint'(e_deq_h[p]));
      chk($sformatf("R8 eof_rel_valid[%0d]", p), longint'(eof_rel_valid[p]), longint'(e_rel_v[p]));
      if (e_rel_v[p]) chk($sformatf("R8 eof_rel_handle[%0d]", p), longint'(eof_rel_handle[p*HW +: HW]), longint'(e_rel_h[p]));
    end
  endtask

  task automatic model();
    logic [NPORT-1:0] kept;
    logic [NPORT-1:0] low;
    int hn [NPORT];
    bit glob;
    int c;
    glob = (int'(buf_used) + int'(buf_resv)) > int'(glob_limit);
    kept = '0;
    for (int p = 0; p < NPORT; p++) begin
      int d;
      d = q[p][int'(fwd_class)].size();
      if (fwd_valid && fwd_mask[p] && !glob && !(d > int'(qdepth_limit)) && d < DEPTH) kept[p] = 1'b1;
    end
    e_adm_v  = fwd_valid;
    e_kept   = kept;
    e_drop_v = fwd_valid && kept == '0;
    e_drop_h = int'(fwd_handle);
    for (int p = 0; p < NPORT; p++) begin
      c = int'(deq_class[p*CLW +: CLW]);
      e_deq_v[p] = deq_req[p] && q[p][c].size() > 0;
      if (e_deq_v[p]) e_deq_h[p] = q[p][c][0];
    end
    for (int p = 0; p < NPORT; p++) begin
      int h;
      h = int'(eof_handle[p*HW +: HW]);
      hn[p] = 0;
      low[p] = 1'b0;
      e_rel_v[p] = 1'b0;
      e_rel_h[p] = h;
      if (eof_valid[p]) begin
        for (int r = 0; r < NPORT; r++)
          if (eof_valid[r] && int'(eof_handle[r*HW +: HW]) == h) begin
            hn[p]++;
            if (r < p) low[p] = 1'b1;
          end
        e_rel_v[p] = cnt[h] > 0 && cnt[h] <= hn[p] && !low[p];
      end
    end
    for (int p = 0; p < NPORT; p++)
      if (e_deq_v[p]) void'(q[p][int'(deq_class[p*CLW +: CLW])].pop_front());
    for (int p = 0; p < NPORT; p++)
      if (kept[p]) q[p][int'(fwd_class)].push_back(int'(fwd_handle));
    for (int p = 0; p < NPORT; p++)
      if (eof_valid[p] && !low[p]) begin
        int h;
        h = int'(eof_handle[p*HW +: HW]);
        if (cnt[h] > 0) cnt[h] = (cnt[h] > hn[p]) ? cnt[h] - hn[p] : 0;
      end
    if (fwd_valid && kept != '0) cnt[int'(fwd_handle)] = $countones(kept);
  endtask

  task automatic tick();
    model();
    @(negedge clk);
    compare();
    fwd_valid = 0; fwd_mask = 0; deq_req = 0; eof_valid = 0;
  endtask

  task automatic send(int h, int c, logic [NPORT-1:0] m);
    fwd_valid = 1; fwd_handle = HW'(h); fwd_class = CLW'(c); fwd_mask = m;
  endtask

  task automatic deq(int p, int c);
    deq_req[p] = 1'b1; deq_class[p*CLW +: CLW] = CLW'(c);
  endtask

  task automatic eof(int p, int h);
    eof_valid[p] = 1'b1; eof_handle[p*HW +: HW] = HW'(h);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int h = 0; h < NH; h++) cnt[h] = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst = 0;
    tick();
    tag = "R6"; send(1, 0, 4'b1111); tick();
    deq(0, 0); tick();
    tag = "R2"; buf_used = 80; buf_resv = 30; send(2, 0, 4'b1111); tick();
    buf_used = 10; buf_resv = 10;
    tag = "R3"; qdepth_limit = 2;
    send(3, 1, 4'b0001); tick();
    send(4, 1, 4'b0001); tick();
    send(5, 1, 4'b0001); tick();
    send(6, 1, 4'b0011); tick();
    tag = "R5"; send(7, 1, 4'b0001); tick();
    send(8, 2, 4'b0000); tick();
    tag = "R4"; qdepth_limit = 15;
    for (int i = 0; i < DEPTH; i++) begin send(10 + i, 3, 4'b0100); tick(); end
    send(18, 3, 4'b0100); tick();
    send(19, 3, 4'b1100); tick();
    deq(2, 3); send(20, 3, 4'b0100); tick();
    tag = "R7"; deq(1, 2); tick();
    tag = "R6"; deq(0, 1); tick();
    deq(0, 1); deq(1, 1); tick();
    deq(0, 1); tick();
    deq(0, 1); tick();
    tag = "R8"; eof(0, 1); tick();
    eof(1, 1); tick();
    tag = "R9"; eof(2, 1); eof(3, 1); tick();
    tag = "R10"; eof(0, 1); tick();
    tag = "R8"; eof(0, 3); tick();
    eof(0, 4); eof(1, 5); tick();
    eof(1, 6); tick();
    tag = "R9"; eof(0, 19); eof(3, 19); tick();
    tag = "R10"; eof(3, 19); tick();
    repeat (3) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule